// File: doc/BRIEF.md
# Reverse-Carry Address Update Unit

This block computes the next value of an address pointer as a post-increment by an offset. It has two arithmetic modes. The linear mode is a plain wrapping binary add. The reverse-carry mode propagates the carry from the most significant bit toward the least significant bit. When the offset is a single power of two, the reverse-carry mode steps a pointer through the scrambled, bit-reversed order that radix-2 FFT passes use to read or write their data.

The caller presents the current address, the offset and the mode, and raises the update strobe for one cycle. On that clock edge the result is loaded into the output register. To walk a sequence, the caller feeds the registered output back as the next current address. A synthesis-time parameter selects how the reverse-carry sum is built: either as an explicit downward ripple chain, or as a standard adder with bit reversal wired around it. Both structures are present so that they can be cross-checked.

Top module: `addr_update_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `next_addr` becomes 0, whatever the other inputs are. The reset is synchronous and takes priority over `upd_en`.
- R2: When `upd_en` is low (and `rst` is low), `next_addr` keeps its value, whatever `cur_addr`, `offset` and `mode_sel` do.
- R3: With `mode_sel` = 0 (linear), an update loads `(cur_addr + offset) mod 2^32`. The add is the same for signed and unsigned views; for example 0xFFFFFFF0 + 0x20 gives 0x10, and 100 + 0xFFFFFFFF gives 99.
- R4: With `mode_sel` = 1 (reverse carry), an update loads `rev(rev(cur_addr) + rev(offset))`, where `rev` mirrors the 32 bits end for end and the inner add wraps modulo 2^32.
- R5: In reverse-carry mode the carry moves from bit 31 toward bit 0, and a carry out of bit 0 is dropped. For example 0x80000000 + 0x80000000 gives 0x40000000, 1 + 1 gives 0, and 3 + 1 gives 2.
- R6: In reverse-carry mode with offset 512, starting from address 0 and feeding each result back, the loaded values are 512, 256, 768, 128, 640 in that order.
- R7: In reverse-carry mode with offset 2^(K-1) and a start address that is a multiple of 2^K, the bits of the address at positions K and above never change. Over 2^K updates the pointer visits every address in the buffer once and returns to the base.
- R8: The offset is taken as an unsigned 32-bit value over its full range. For example, in reverse-carry mode an offset of 0xFFFFFFFF from address 0 gives 0xFFFFFFFF.
- R9: The ripple-chain form (`RC_STYLE` = 0) and the mirrored-adder form (`RC_STYLE` = 1) of the reverse-carry sum agree bit for bit on every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update strobe; loads the computed address when high |
| mode_sel | input | 1 | 0 = linear add, 1 = reverse-carry add |
| cur_addr | input | AW | Current address value |
| offset | input | AW | Unsigned step value |
| next_addr | output | AW | Registered updated address |

## Verification
The bench targets the carry at both ends of the word. A design that ran the reverse carry upward would turn 0x80000000 + 0x80000000 into 0 instead of 0x40000000. A design that wrapped the carry from bit 0 back to the top would turn 1 + 1 into something nonzero. A 16-step FFT walk inside a buffer at base 0x30 would catch a chain that leaked carries above bit K-1: the pointer would leave the buffer or repeat an address. The bench also feeds an all-ones offset, which exposes any signed or narrowed treatment of the offset. It compares two instances built with different `RC_STYLE` values on random operands, which would expose a mismatch between the ripple and mirrored structures.

// File: rtl/addr_upd_pkg.sv
package addr_upd_pkg;

  typedef enum logic {
    MODE_LINEAR  = 1'b0,
    MODE_REVCARRY = 1'b1
  } upd_mode_e;

  localparam int RC_RIPPLE = 0;
  localparam int RC_MIRROR = 1;

endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar gi = 0; gi < W; gi++) begin : g_swap
    assign dout[gi] = din[W-1-gi];
  end

endmodule

// File: rtl/rc_ripple_add.sv
module rc_ripple_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  // cy[i] is the carry entering bit i-1 from bit i; the chain starts at the MSB
  logic [W:1] cy;

  assign cy[W] = 1'b0;

  for (genvar gi = W - 1; gi >= 0; gi--) begin : g_bit
    assign sum[gi] = a[gi] ^ b[gi] ^ cy[gi+1];
    if (gi > 0) begin : g_carry
      assign cy[gi] = (a[gi] & b[gi]) | (cy[gi+1] & (a[gi] ^ b[gi]));
    end
  end

endmodule

// File: rtl/rc_mirror_add.sv
module rc_mirror_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  logic [W-1:0] a_rev;
  logic [W-1:0] b_rev;
  logic [W-1:0] s_rev;

  bit_mirror #(.W(W)) u_mir_a (.din(a), .dout(a_rev));
  bit_mirror #(.W(W)) u_mir_b (.din(b), .dout(b_rev));

  assign s_rev = a_rev + b_rev;

  bit_mirror #(.W(W)) u_mir_s (.din(s_rev), .dout(sum));

endmodule

// File: rtl/addr_update_unit.sv
module addr_update_unit
  import addr_upd_pkg::*;
#(
  parameter int AW       = 32,
  parameter int RC_STYLE = RC_RIPPLE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic          mode_sel,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] next_addr
);

  upd_mode_e     mode;
  logic [AW-1:0] lin_sum;
  logic [AW-1:0] ripple_sum;
  logic [AW-1:0] mirror_sum;
  logic [AW-1:0] rc_sum;
  logic [AW-1:0] upd_val;
  logic [AW-1:0] addr_q;

  assign mode    = upd_mode_e'(mode_sel);
  assign lin_sum = cur_addr + offset;

  rc_ripple_add #(.W(AW)) u_ripple (
    .a   (cur_addr),
    .b   (offset),
    .sum (ripple_sum)
  );

  rc_mirror_add #(.W(AW)) u_mirror (
    .a   (cur_addr),
    .b   (offset),
    .sum (mirror_sum)
  );

  if (RC_STYLE == RC_MIRROR) begin : g_use_mirror
    assign rc_sum = mirror_sum;
  end else begin : g_use_ripple
    assign rc_sum = ripple_sum;
  end

  always_comb begin
    unique case (mode)
      MODE_REVCARRY: upd_val = rc_sum;
      default:       upd_val = lin_sum;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (upd_en) begin
      addr_q <= upd_val;
    end
  end

  assign next_addr = addr_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (addr_q == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(addr_q)); // R2

  AST_LINEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !mode_sel) |=> (addr_q == AW'($past(cur_addr) + $past(offset)))); // R3

  AST_FORMS_MATCH: assert property (@(posedge clk) disable iff (rst)
    ripple_sum == mirror_sum); // R9

  AST_HIGH_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (upd_en && mode_sel && $onehot(offset)) |=>
      ((($past(cur_addr) ^ addr_q) & ~(AW'($past(offset) << 1) - AW'(1))) == '0)); // R7

endmodule

// File: tb/test_addr_update_unit.sv
module test_addr_update_unit;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          upd_en;
  logic          mode_sel;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] offset;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] next_addr_m;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  addr_update_unit #(.AW(AW), .RC_STYLE(0)) i_addr_update_unit (
    .clk(clk), .rst(rst), .upd_en(upd_en), .mode_sel(mode_sel),
    .cur_addr(cur_addr), .offset(offset), .next_addr(next_addr)
  );

  addr_update_unit #(.AW(AW), .RC_STYLE(1)) i_addr_update_unit_mirror (
    .clk(clk), .rst(rst), .upd_en(upd_en), .mode_sel(mode_sel),
    .cur_addr(cur_addr), .offset(offset), .next_addr(next_addr_m)
  );

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  function automatic logic [AW-1:0] ref_rc(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return flip(flip(a) + flip(b));
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // drive one update at a falling edge; result is registered at the next rising edge
  task automatic step(input logic m, input logic [AW-1:0] a, input logic [AW-1:0] o);
    @(negedge clk);
    upd_en = 1'b1; mode_sel = m; cur_addr = a; offset = o;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; upd_en = 1'b1; mode_sel = 1'b1;
    cur_addr = 32'h1234_5678; offset = 32'h0000_0100;
    repeat (3) @(negedge clk);
    check("R1 reset dominates strobe", next_addr, '0);
    rst = 1'b0; upd_en = 1'b0;
    @(negedge clk);
    check("R1 value after reset release", next_addr, '0);
  endtask

  task automatic t_hold();
    step(1'b0, 32'h0000_1000, 32'h0000_0234);
    check("R3 linear load", next_addr, 32'h0000_1234);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      mode_sel = i[0]; cur_addr = 32'hDEAD_0000 + i; offset = 32'h0F0F_0F0F;
    end
    @(negedge clk);
    check("R2 hold with strobe low", next_addr, 32'h0000_1234);
  endtask

  task automatic t_linear();
    step(1'b0, 32'hFFFF_FFF0, 32'h0000_0020);
    check("R3 linear wrap", next_addr, 32'h0000_0010);
    step(1'b0, 32'd100, 32'hFFFF_FFFF);
    check("R3 linear negative step", next_addr, 32'd99);
  endtask

  task automatic t_carry_ends();
    step(1'b1, 32'h8000_0000, 32'h8000_0000);
    check("R5 msb carry moves down", next_addr, 32'h4000_0000);
    step(1'b1, 32'h0000_0001, 32'h0000_0001);
    check("R5 lsb carry dropped", next_addr, 32'h0000_0000);
    step(1'b1, 32'h0000_0003, 32'h0000_0001);
    check("R5 carry into bit0", next_addr, 32'h0000_0002);
    step(1'b1, 32'h0000_0000, 32'hFFFF_FFFF);
    check("R8 full-range offset", next_addr, 32'hFFFF_FFFF);
    step(1'b1, 32'h0000_0001, 32'hFFFF_FFFF);
    check("R8 full-range offset nonzero base", next_addr, ref_rc(32'h1, 32'hFFFF_FFFF));
  endtask

  task automatic t_fft512();
    logic [AW-1:0] exp_seq [5] = '{32'd512, 32'd256, 32'd768, 32'd128, 32'd640};
    logic [AW-1:0] a = '0;
    for (int i = 0; i < 5; i++) begin
      step(1'b1, a, 32'd512);
      check("R6 fft512 sequence", next_addr, exp_seq[i]);
      a = next_addr;
    end
  endtask

  task automatic t_buffer_walk();
    logic [15:0] seen = '0;
    logic [AW-1:0] a = 32'h0000_0030;
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      step(1'b1, a, 32'd8);
      if ((next_addr & ~32'hF) != 32'h30) bad++;
      else if (seen[next_addr[3:0]] && i != 15) bad++;
      seen[next_addr[3:0]] = 1'b1;
      a = next_addr;
    end
    check("R7 walk stays in buffer, no repeats", 32'(bad), 32'd0);
    check("R7 all 16 slots visited", {16'h0, seen}, 32'h0000_FFFF);
    check("R7 returns to base", next_addr, 32'h0000_0030);
  endtask

  task automatic t_random();
    int bad = 0;
    int mism = 0;
    for (int i = 0; i < 200; i++) begin
      logic [AW-1:0] a = $urandom();
      logic [AW-1:0] o = $urandom();
      step(1'b1, a, o);
      if (next_addr !== ref_rc(a, o)) begin
        bad++;
        if (bad == 1) check("R4 random reverse-carry", next_addr, ref_rc(a, o));
      end
      if (next_addr !== next_addr_m) begin
        mism++;
        if (mism == 1) check("R9 ripple vs mirror", next_addr_m, next_addr);
      end
    end
    if (bad == 0) check("R4 random reverse-carry", 32'h0, 32'h0);
    if (mism == 0) check("R9 ripple vs mirror", 32'h0, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    t_reset();
    t_hold();
    t_linear();
    t_carry_ends();
    t_fft512();
    t_buffer_walk();
    t_random();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule